// File: doc/BRIEF.md
# PSRAM Power Sequencer

This block sits between a pseudo-static RAM and its access controller and is the only driver of the memory's two enable pins: the active-low primary select and the active-low power-down line. When the supply comes up it keeps both lines inactive (high) for a long initialization window. It then pulls the primary select low and grants access to the controller. Later it can put the memory to sleep and wake it again. Every transition follows the ordering the memory needs: the primary select rises first, there is a setup gap before the power-down line falls, there is a minimum hold in power-down, and a full re-initialization window follows the rise of the power-down line.

Requests to sleep and wake may arrive at any time. Each is latched as pending and served only when the current timed window has finished. A sleep request also waits until the access controller reports that it is idle. While the memory is powered down its cells are not refreshed. The sequencer counts the cycles spent in power-down. When that time passes a configurable limit it raises a sticky warning that the memory contents can no longer be trusted. Only a complete power-up initialization clears the warning. All windows are given in clock cycles.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset, and while `pwr_good` is low, `mem_ce_n` = 1, `mem_pd_n` = 1 and `acc_grant` = 0. Reset clears `data_lost` to 0.
- R2: After the first clock edge that samples `pwr_good` high, both enable lines stay high and `acc_grant` stays low for INIT_CYC cycles. `acc_grant` rises (with `mem_ce_n` low) on the INIT_CYC+1-th edge.
- R3: `acc_grant` is 1 only while `mem_ce_n` = 0 and `mem_pd_n` = 1, and this is the only state in which `mem_ce_n` is low.
- R4: A pending sleep request does not take away the grant while `acc_idle` is low.
- R5: On the way to power-down, `mem_ce_n` is high for exactly STBY_CYC + SETUP_CYC cycles before `mem_pd_n` falls. The first STBY_CYC of these cycles are the standby entry window.
- R6: `mem_ce_n` is high for the whole time `mem_pd_n` is low. `mem_pd_n` stays low for at least HOLD_CYC cycles, and for exactly HOLD_CYC cycles when a wake request is already pending by then.
- R7: `mem_pd_n` rises while `mem_ce_n` is high. `mem_ce_n` then stays high for EXIT_CYC cycles before the grant returns.
- R8: A wake request that arrives during the standby entry window returns the block to the granted state, and `mem_pd_n` never falls.
- R9: A wake request received while access is granted has no effect. A later sleep request still reaches power-down.
- R10: A sleep request received during the initialization window is held and served once the grant is given and the controller is idle.
- R11: `data_lost` rises after more than LOSS_LIMIT consecutive cycles in power-down. A shorter power-down leaves it at 0.
- R12: `data_lost` stays set across wake-ups and across supply loss. Only the initialization window that follows a return of `pwr_good` clears it.
- R13: One clock edge after `pwr_good` is sampled low, from any state, `mem_ce_n` = 1, `mem_pd_n` = 1 and `acc_grant` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply has reached its minimum operating level |
| sleep_req | input | 1 | Request to enter deep power-down (one-cycle pulse or level) |
| wake_req | input | 1 | Request to leave standby or power-down |
| acc_idle | input | 1 | Access controller has no cycle in progress |
| mem_ce_n | output | 1 | Primary select to the memory, active low |
| mem_pd_n | output | 1 | Power-down line to the memory, low = deep power-down |
| acc_grant | output | 1 | Access to the memory is allowed |
| data_lost | output | 1 | Sticky warning: power-down outlasted the refresh limit |

## Verification
The bound checker watches several rules on every cycle. The grant is never given unless the pins allow access. The primary select is high whenever the power-down line is low. Enough select-high cycles come before each fall of the power-down line, and enough low cycles come before each rise. A supply drop is answered on the next cycle, and the loss warning only clears while the memory is inactive. Other behaviours can only be shown by the bench's scenarios, because they depend on the history of requests: the exact initialization and wake-up durations, the gating by the idle flag, requests held pending or discarded, cancelling a sleep with a wake, and which side of the refresh limit sets the loss flag.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,   // waiting for supply
        PS_INIT  = 3'd1,   // initialization hold, both lines high
        PS_RUN   = 3'd2,   // access granted
        PS_STBY  = 3'd3,   // standby entry window
        PS_PDSET = 3'd4,   // setup before power-down line falls
        PS_PD    = 3'd5,   // deep power-down
        PS_WAKE  = 3'd6    // re-initialization after power-down
    } pwr_state_e;

    typedef struct packed {
        logic ce_n;
        logic pd_n;
        logic grant;
    } pin_set_t;

    function automatic pin_set_t pins_of(pwr_state_e s);
        pin_set_t p;
        p.ce_n  = 1'b1;
        p.pd_n  = 1'b1;
        p.grant = 1'b0;
        case (s)
            PS_RUN: begin
                p.ce_n  = 1'b0;
                p.grant = 1'b1;
            end
            PS_PD:   p.pd_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

    function automatic int lmax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_win_timer.sv
module psram_win_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/psram_req_hold.sv
module psram_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
    end
endmodule

// File: rtl/psram_loss_track.sv
module psram_loss_track #(
    parameter int LOSS_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pd,
    input  logic clr,
    output logic lost
);
    localparam int CW = $clog2(LOSS_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LOSS_LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            lost <= 1'b0;
        end else begin
            // R11, R12: sticky until the initialization window
            if (clr)
                lost <= 1'b0;
            else if (in_pd && cnt == LIM)
                lost <= 1'b1;
            if (!in_pd)
                cnt <= '0;
            else if (cnt != LIM)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int INIT_CYC   = 15000,
    parameter int EXIT_CYC   = 15000,
    parameter int STBY_CYC   = 1,
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 4,
    parameter int LOSS_LIMIT = 3200000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic acc_idle,
    output logic mem_ce_n,
    output logic mem_pd_n,
    output logic acc_grant,
    output logic data_lost
);
    localparam int MAXLEN = lmax(lmax(lmax(INIT_CYC, EXIT_CYC), lmax(STBY_CYC, SETUP_CYC)), HOLD_CYC);
    localparam int TW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
    localparam logic [TW-1:0] INIT_LD = TW'(INIT_CYC - 1);
    localparam logic [TW-1:0] EXIT_LD = TW'(EXIT_CYC - 1);
    localparam logic [TW-1:0] STBY_LD = TW'(STBY_CYC - 1);
    localparam logic [TW-1:0] SET_LD  = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);

    pwr_state_e    st, st_nxt;
    logic          ld;
    logic [TW-1:0] ld_val;
    logic          win_done;
    logic          sleep_pend, wake_pend;
    logic          clr_sleep, clr_wake;
    pin_set_t      pins;

    psram_win_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .done     (win_done)
    );

    // R10: requests are held until the current window completes
    psram_req_hold u_sleep_hold (
        .clk  (clk),
        .rst  (rst),
        .set  (sleep_req),
        .clr  (clr_sleep),
        .pend (sleep_pend)
    );

    psram_req_hold u_wake_hold (
        .clk  (clk),
        .rst  (rst),
        .set  (wake_req),
        .clr  (clr_wake),
        .pend (wake_pend)
    );

    psram_loss_track #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
        .clk   (clk),
        .rst   (rst),
        .in_pd (st == PS_PD),
        .clr   (st == PS_INIT),
        .lost  (data_lost)
    );

    always_comb begin
        st_nxt    = st;
        ld        = 1'b0;
        ld_val    = '0;
        clr_sleep = 1'b0;
        clr_wake  = 1'b0;
        if (!pwr_good) begin
            // R13: supply loss forces the inactive state from anywhere
            st_nxt    = PS_OFF;
            clr_sleep = 1'b1;
            clr_wake  = 1'b1;
        end else begin
            case (st)
                PS_OFF: begin
                    clr_sleep = 1'b1;
                    clr_wake  = 1'b1;
                    st_nxt    = PS_INIT;
                    ld        = 1'b1;
                    ld_val    = INIT_LD;
                end
                PS_INIT: if (win_done) st_nxt = PS_RUN;
                PS_RUN: begin
                    clr_wake = 1'b1;          // R9
                    if (sleep_pend && acc_idle) begin   // R4
                        st_nxt = PS_STBY;
                        ld     = 1'b1;
                        ld_val = STBY_LD;
                    end
                end
                PS_STBY: if (win_done) begin
                    if (wake_pend) begin      // R8
                        st_nxt    = PS_RUN;
                        clr_sleep = 1'b1;
                        clr_wake  = 1'b1;
                    end else begin
                        st_nxt = PS_PDSET;
                        ld     = 1'b1;
                        ld_val = SET_LD;
                    end
                end
                PS_PDSET: if (win_done) begin
                    st_nxt    = PS_PD;
                    ld        = 1'b1;
                    ld_val    = HOLD_LD;
                    clr_sleep = 1'b1;
                end
                PS_PD: if (win_done && wake_pend) begin   // R6, R7
                    st_nxt   = PS_WAKE;
                    ld       = 1'b1;
                    ld_val   = EXIT_LD;
                    clr_wake = 1'b1;
                end
                PS_WAKE: if (win_done) st_nxt = PS_RUN;
                default: st_nxt = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PS_OFF;
        else     st <= st_nxt;
    end

    assign pins      = pins_of(st);
    assign mem_ce_n  = pins.ce_n;
    assign mem_pd_n  = pins.pd_n;
    assign acc_grant = pins.grant;
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
    parameter int STBY_CYC  = 1,
    parameter int SETUP_CYC = 1,
    parameter int HOLD_CYC  = 4
) (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic mem_ce_n,
    input logic mem_pd_n,
    input logic acc_grant,
    input logic data_lost
);
    localparam int CAP = (STBY_CYC + SETUP_CYC > HOLD_CYC) ? STBY_CYC + SETUP_CYC : HOLD_CYC;
    localparam int CW  = $clog2(CAP + 1);
    localparam logic [CW-1:0] CAPV = CW'(CAP);
    localparam logic [CW-1:0] PRE  = CW'(STBY_CYC + SETUP_CYC);
    localparam logic [CW-1:0] HLD  = CW'(HOLD_CYC);

    logic [CW-1:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= !mem_ce_n ? '0 : ((hi_cnt == CAPV) ? CAPV : hi_cnt + 1'b1);
            lo_cnt <= mem_pd_n  ? '0 : ((lo_cnt == CAPV) ? CAPV : lo_cnt + 1'b1);
        end
    end

    a_r3_grant_pins: assert property (@(posedge clk) disable iff (rst)
        acc_grant |-> (!mem_ce_n && mem_pd_n));

    a_r6_select_high_in_pd: assert property (@(posedge clk) disable iff (rst)
        !mem_pd_n |-> mem_ce_n);

    a_r5_setup_before_pd: assert property (@(posedge clk) disable iff (rst)
        (!mem_pd_n && $past(mem_pd_n)) |-> (hi_cnt >= PRE));

    a_r7_select_high_at_exit: assert property (@(posedge clk) disable iff (rst)
        (mem_pd_n && !$past(mem_pd_n)) |-> mem_ce_n);

    a_r6_hold_window: assert property (@(posedge clk) disable iff (rst)
        (mem_pd_n && !$past(mem_pd_n) && $past(pwr_good)) |-> (lo_cnt >= HLD));

    a_r13_supply_drop: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (mem_ce_n && mem_pd_n && !acc_grant));

    a_r12_lost_clear_inactive: assert property (@(posedge clk) disable iff (rst)
        $fell(data_lost) |-> (mem_ce_n && mem_pd_n && !acc_grant));
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .STBY_CYC  (STBY_CYC),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .mem_ce_n  (mem_ce_n),
    .mem_pd_n  (mem_pd_n),
    .acc_grant (acc_grant),
    .data_lost (data_lost)
);

// File: tb/psram_pwr_seq_bench.sv
`timescale 1ns/1ps
module psram_pwr_seq_bench;
    localparam int INIT = 40;
    localparam int EXIT = 30;
    localparam int STBY = 3;
    localparam int SETC = 2;
    localparam int HOLD = 5;
    localparam int LIM  = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, acc_idle = 1'b1;
    logic mem_ce_n, mem_pd_n, acc_grant, data_lost;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    psram_pwr_seq #(
        .INIT_CYC(INIT), .EXIT_CYC(EXIT), .STBY_CYC(STBY),
        .SETUP_CYC(SETC), .HOLD_CYC(HOLD), .LOSS_LIMIT(LIM)
    ) u_psram_pwr_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .sleep_req(sleep_req),
        .wake_req(wake_req), .acc_idle(acc_idle), .mem_ce_n(mem_ce_n),
        .mem_pd_n(mem_pd_n), .acc_grant(acc_grant), .data_lost(data_lost)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    // States: 0 off, 1 init, 2 granted, 3 standby window, 4 setup, 5 power-down, 6 wake hold
    int m_st = 0, m_t = 0, m_pc = 0;
    bit m_sp = 0, m_wp = 0, m_lost = 0;
    int n_st, n_lv;
    bit n_ld, n_cs, n_cw;

    function automatic int win_len(int s);
        case (s)
            1: return INIT;
            3: return STBY;
            4: return SETC;
            5: return HOLD;
            6: return EXIT;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_t = 0; m_pc = 0; m_sp = 0; m_wp = 0; m_lost = 0;
        end else begin
            n_st = m_st; n_ld = 0; n_cs = 0; n_cw = 0;
            if (!pwr_good) begin
                n_st = 0; n_cs = 1; n_cw = 1;
            end else begin
                case (m_st)
                    0: begin n_st = 1; n_ld = 1; n_cs = 1; n_cw = 1; end
                    1: if (m_t == 0) n_st = 2;
                    2: begin n_cw = 1; if (m_sp && acc_idle) begin n_st = 3; n_ld = 1; end end
                    3: if (m_t == 0) begin
                           if (m_wp) begin n_st = 2; n_cs = 1; n_cw = 1; end
                           else begin n_st = 4; n_ld = 1; end
                       end
                    4: if (m_t == 0) begin n_st = 5; n_ld = 1; n_cs = 1; end
                    5: if (m_t == 0 && m_wp) begin n_st = 6; n_ld = 1; n_cw = 1; end
                    default: if (m_t == 0) n_st = 2;
                endcase
            end
            if (m_st == 5) begin
                if (m_pc == LIM) m_lost = 1; else m_pc++;
            end else m_pc = 0;
            if (m_st == 1) m_lost = 0;
            m_sp = n_cs ? 1'b0 : (m_sp | sleep_req);
            m_wp = n_cw ? 1'b0 : (m_wp | wake_req);
            if (n_ld) m_t = win_len(n_st) - 1;
            else if (m_t != 0) m_t--;
            m_st = n_st;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk(tag_of(m_st), mem_ce_n,  (m_st == 2) ? 0 : 1);
            chk(tag_of(m_st), mem_pd_n,  (m_st == 5) ? 0 : 1);
            chk("R3",         acc_grant, (m_st == 2) ? 1 : 0);
            chk("R11",        data_lost, m_lost);
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    endtask

    task automatic wait_grant(int lim);
        for (int i = 0; i < lim && !acc_grant; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int n;
        bit saw_low;
        void'($urandom(32'd4711));
        tick(5);
        // R1: reset state
        chk("R1", mem_ce_n, 1); chk("R1", mem_pd_n, 1);
        chk("R1", acc_grant, 0); chk("R1", data_lost, 0);
        rst = 1'b0;
        tick(5);
        chk("R1", acc_grant, 0);

        // R2: initialization duration
        pwr_good = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!acc_grant && n < 1000);
        chk("R2", n, INIT + 1);
        chk("R2", mem_ce_n, 0);

        // R4: sleep held off while the controller is busy
        acc_idle = 1'b0;
        pulse_sleep();
        tick(20);
        chk("R4", acc_grant, 1);
        acc_idle = 1'b1;
        while (acc_grant) @(negedge clk);

        // R5: select-high cycles before the power-down line falls
        n = 0;
        while (mem_pd_n && n < 100) begin n++; @(negedge clk); end
        chk("R5", n, STBY + SETC);

        // R6: hold in power-down with a wake already pending
        wake_req = 1'b1;
        n = 0;
        while (!mem_pd_n && n < 100) begin n++; @(negedge clk); wake_req = 1'b0; end
        chk("R6", n, HOLD);

        // R7: re-initialization after exit
        chk("R7", mem_ce_n, 1);
        n = 0;
        while (!acc_grant && n < 1000) begin @(negedge clk); n++; end
        chk("R7", n, EXIT);
        chk("R11", data_lost, 0);

        // R9: wake while granted is dropped
        pulse_wake();
        tick(3);
        pulse_sleep();
        saw_low = 0;
        for (int i = 0; i < 50 && !saw_low; i++) begin
            @(negedge clk);
            if (!mem_pd_n) saw_low = 1;
        end
        chk("R9", saw_low, 1);

        // R11: long power-down sets the loss flag
        tick(2 * LIM + 10);
        chk("R11", data_lost, 1);
        pulse_wake();
        wait_grant(200);
        chk("R12", data_lost, 1);

        // R8: wake during the standby entry window cancels the sleep
        pulse_sleep();
        tick(1);
        pulse_wake();
        saw_low = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!mem_pd_n) saw_low = 1;
        end
        chk("R8", saw_low, 0);
        chk("R8", acc_grant, 1);

        // R13: supply drop
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R13", mem_ce_n, 1); chk("R13", mem_pd_n, 1); chk("R13", acc_grant, 0);
        chk("R12", data_lost, 1);
        tick(3);

        // R10, R12: sleep during initialization is held; flag cleared by init
        pwr_good = 1'b1;
        tick(4);
        pulse_sleep();
        wait_grant(INIT + 10);
        chk("R12", data_lost, 0);
        saw_low = 0;
        for (int i = 0; i < 30 && !saw_low; i++) begin
            @(negedge clk);
            if (!mem_pd_n) saw_low = 1;
        end
        chk("R10", saw_low, 1);
        pulse_wake();
        wait_grant(200);

        // Random phase checked against the reference model every cycle
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            sleep_req = ($urandom % 20) == 0;
            wake_req  = ($urandom % 25) == 0;
            acc_idle  = ($urandom % 4) != 0;
            if (pwr_good) pwr_good = ($urandom % 500) != 0;
            else          pwr_good = ($urandom % 4) == 0;
        end
        sleep_req = 1'b0; wake_req = 1'b0;
        tick(2);
        finish_run();
    end
endmodule